// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital half of a voltage comparator peripheral. A raw one-bit comparison result arrives with no timing relation to the system clock. The block passes it through a chain of flip-flops and shows the settled value as a read-only bit in an 8-bit control and status register. A two-bit mode field picks which change of that settled value counts as an event: any change, a falling edge or a rising edge. One code is reserved and never counts.

An event sets a sticky flag. Software clears the flag by writing a one to it. Hardware clears it when the interrupt vector is acknowledged. An interrupt request is raised while the flag, a local enable and a chip-wide interrupt enable are all high. The register also holds three more controls:
- a bit that selects the internal reference as the positive input;
- a bit that turns the comparator off and freezes the synchronizer;
- a bit that forwards the synchronized result to a timer capture input.

The block carries no data stream, so every pin is plain control or status and none uses a handshake. Register writes take effect on the clock edge where the write strobe is high. Reads are combinational from held state.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, every writable field is 0, the flag is 0, the output bit (bit 5) reads 0, and `irq` and `capt_out` are low.
- R2: A write stores bits 7, 6, 3, 2, 1 and 0 of `reg_wdata`. Bit 5 of a write is ignored. The register reads back as {off[7], ref_sel[6], out[5], flag[4], ie[3], cap_en[2], mode[1:0]}.
- R3: With the comparator on, a change on `cmp_raw` set up before a clock edge appears in bit 5 after exactly two rising edges.
- R4: With mode 2'b00, every change of bit 5 sets the flag on the next edge.
- R5: Mode 2'b10 sets the flag only on a 1-to-0 change of bit 5. Mode 2'b11 sets it only on a 0-to-1 change.
- R6: Mode 2'b01 never sets the flag.
- R7: Writing 1 to bit 4 or asserting `vec_ack` clears the flag. Writing 0 to bit 4 leaves it unchanged. When an event and a clear fall in the same cycle, the flag ends set.
- R8: `irq` is high exactly when the flag, bit 3 and `global_ie` are all 1.
- R9: `capt_out` follows bit 5 while bit 2 is 1, and is 0 while bit 2 is 0.
- R10: `pos_src_sel` equals bit 6 and `cmp_off` equals bit 7.
- R11: While bit 7 is 1, bit 5 holds its value and no event sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator result, 1 when positive input is higher |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| global_ie | input | 1 | Chip-wide interrupt enable |
| vec_ack | input | 1 | Interrupt vector taken; clears the flag |
| irq | output | 1 | Interrupt request |
| pos_src_sel | output | 1 | 1 selects the internal reference as positive input |
| cmp_off | output | 1 | 1 powers the comparator down |
| capt_out | output | 1 | Synchronized result routed to the timer capture input |

## Verification
The hardest situation to reach is an edge event in the same cycle as a flag clear. That cycle is set by the two-edge synchronizer delay, not by the stimulus directly. The bench reaches it in two ways. It toggles `cmp_raw` on a short period while writing the clear bit on every cycle, so some write always lands on the event cycle. It also runs a long stretch of random raw, write and acknowledge traffic. A cycle-accurate reference model checks every cycle, so each such collision is judged when it happens. Turning the comparator off in the middle of a transition, and back on again, is also driven on purpose.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int REG_W    = 8;
  localparam int B_OFF    = 7;
  localparam int B_REFSEL = 6;
  localparam int B_OUT    = 5;
  localparam int B_FLAG   = 4;
  localparam int B_IE     = 3;
  localparam int B_CAP    = 2;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_RSVD = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       off;
    logic       ref_sel;
    logic       ie;
    logic       cap_en;
    edge_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     pipe <= '0;
        else if (!hold) pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n)     pipe <= '0;
        else if (!hold) pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       active,
  input  edge_mode_e mode,
  output logic       evt
);
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sample;
  end

  assign rise = sample & ~prev;
  assign fall = ~sample & prev;

  always_comb begin
    unique case (mode)
      EDGE_ANY:  evt = rise | fall;
      EDGE_FALL: evt = fall;
      EDGE_RISE: evt = rise;
      default:   evt = 1'b0;
    endcase
    if (!active) evt = 1'b0;
  end
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_evt,
  input  logic             vec_ack,
  output ctrl_t            ctrl,
  output logic             flag
);
  logic clr;

  assign clr = (wr_en & wdata[B_FLAG]) | vec_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.off     <= wdata[B_OFF];
      ctrl.ref_sel <= wdata[B_REFSEL];
      ctrl.ie      <= wdata[B_IE];
      ctrl.cap_en  <= wdata[B_CAP];
      ctrl.mode    <= edge_mode_e'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_evt | (flag & ~clr);
  end
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             global_ie,
  input  logic             vec_ack,
  output logic             irq,
  output logic             pos_src_sel,
  output logic             cmp_off,
  output logic             capt_out
);
  ctrl_t ctrl;
  logic  flag;
  logic  cmp_s;
  logic  evt;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (ctrl.off),
    .din  (cmp_raw),
    .dout (cmp_s)
  );

  cmp_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(cmp_s),
    .active(~ctrl.off),
    .mode  (ctrl.mode),
    .evt   (evt)
  );

  cmp_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wdata  (reg_wdata),
    .set_evt(evt),
    .vec_ack(vec_ack),
    .ctrl   (ctrl),
    .flag   (flag)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[B_OFF]    = ctrl.off;
    reg_rdata[B_REFSEL] = ctrl.ref_sel;
    reg_rdata[B_OUT]    = cmp_s;
    reg_rdata[B_FLAG]   = flag;
    reg_rdata[B_IE]     = ctrl.ie;
    reg_rdata[B_CAP]    = ctrl.cap_en;
    reg_rdata[1:0]      = ctrl.mode;
  end

  assign irq         = flag & ctrl.ie & global_ie;
  assign pos_src_sel = ctrl.ref_sel;
  assign cmp_off     = ctrl.off;
  assign capt_out    = ctrl.cap_en & cmp_s;
endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       global_ie,
  input logic       vec_ack,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic       capt_out,
  input logic       pos_src_sel,
  input logic       cmp_off
);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (global_ie && reg_rdata[4] && reg_rdata[3]));

  p_rsvd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] == 2'b01 && !reg_rdata[4]) |=> !reg_rdata[4]);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && reg_rdata[1:0] == 2'b01) |=> !reg_rdata[4]);

  p_off_no_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !reg_rdata[4]) |=> !reg_rdata[4]);

  p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |=> $stable(reg_rdata[5]));

  p_capt_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[2] |-> !capt_out);

  p_ctl_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_src_sel == reg_rdata[6]) && (cmp_off == reg_rdata[7]));
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .global_ie  (global_ie),
  .vec_ack    (vec_ack),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .capt_out   (capt_out),
  .pos_src_sel(pos_src_sel),
  .cmp_off    (cmp_off)
);

// File: tb/cmp_evt_ctrl_test.sv
module cmp_evt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       global_ie = 1'b0;
  logic       vec_ack = 1'b0;
  logic       irq, pos_src_sel, cmp_off, capt_out;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cmp_evt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .global_ie(global_ie), .vec_ack(vec_ack), .irq(irq),
    .pos_src_sel(pos_src_sel), .cmp_off(cmp_off), .capt_out(capt_out)
  );

  // reference model state
  bit m_off, m_ref, m_ie, m_cap, m_flag;
  bit [1:0] m_mode;
  bit m_hist[$];
  bit m_seen, m_prev;

  initial begin
    m_hist.push_back(1'b0);
  end

  always @(posedge clk) begin
    bit ev, nf, clr;
    if (!rst_n) begin
      {m_off, m_ref, m_ie, m_cap, m_flag, m_mode} = '0;
      m_hist.delete();
      m_hist.push_back(1'b0);
      m_seen = 1'b0;
      m_prev = 1'b0;
    end else begin
      ev = 1'b0;
      if (!m_off) begin
        if (m_mode == 2'b00) ev = (m_seen != m_prev);
        if (m_mode == 2'b10) ev = (!m_seen && m_prev);
        if (m_mode == 2'b11) ev = (m_seen && !m_prev);
      end
      clr = (reg_wr_en && reg_wdata[4]) || vec_ack;
      nf = ev || (m_flag && !clr);
      m_prev = m_seen;
      if (!m_off) begin
        m_hist.push_back(cmp_raw);
        m_seen = m_hist.pop_front();
      end
      if (reg_wr_en) begin
        m_off  = reg_wdata[7];
        m_ref  = reg_wdata[6];
        m_ie   = reg_wdata[3];
        m_cap  = reg_wdata[2];
        m_mode = reg_wdata[1:0];
      end
      m_flag = nf;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_r;
    exp_r = {m_off, m_ref, m_seen, m_flag, m_ie, m_cap, m_mode};
    chk("rdata", reg_rdata, exp_r);
    chk("irq", {7'd0, irq}, {7'd0, m_flag & m_ie & global_ie});
    chk("capt_out", {7'd0, capt_out}, {7'd0, m_cap & m_seen});
    chk("pos_src_sel", {7'd0, pos_src_sel}, {7'd0, m_ref});
    chk("cmp_off", {7'd0, cmp_off}, {7'd0, m_off});
  endtask

  // one cycle: compare at the falling edge, then drive new inputs
  task automatic cyc(bit raw, bit wr, bit [7:0] wd, bit ack, bit gie);
    @(negedge clk);
    if (rst_n) compare_all();
    cmp_raw   = raw;
    reg_wr_en = wr;
    reg_wdata = wd;
    vec_ack   = ack;
    global_ie = gie;
  endtask

  task automatic idle(bit raw, int n);
    for (int i = 0; i < n; i++) cyc(raw, 1'b0, 8'h00, 1'b0, global_ie);
  endtask

  task automatic wr(bit raw, bit [7:0] wd);
    cyc(raw, 1'b1, wd, 1'b0, global_ie);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("reset rdata", reg_rdata, 8'h00);
    chk("reset irq", {7'd0, irq}, 8'h00);
    chk("reset capt", {7'd0, capt_out}, 8'h00);
    idle(0, 2);

    // R2: field writes, bit 5 ignored on write
    cur_req = "R2";
    wr(0, 8'hEF); idle(0, 2);
    wr(0, 8'h2B); idle(0, 2);
    wr(0, 8'h00); idle(0, 2);

    // R10: reference select and power-down pins
    cur_req = "R10";
    wr(0, 8'h40); idle(0, 2);
    wr(0, 8'hC0); idle(0, 2);
    wr(0, 8'h00); idle(0, 2);

    // R3: two-edge synchronizer latency
    cur_req = "R3";
    idle(1, 4);
    @(negedge clk); chk("out after 2 edges", {7'd0, reg_rdata[5]}, 8'h01);
    idle(0, 1);
    @(negedge clk); chk("out still 1 after 1 edge", {7'd0, reg_rdata[5]}, 8'h01);
    idle(0, 3);
    wr(0, 8'h10); idle(0, 2);

    // R4: any-change mode
    cur_req = "R4";
    wr(0, 8'h10);
    for (int k = 0; k < 4; k++) begin idle(1, 4); wr(1, 8'h10); idle(0, 4); wr(0, 8'h10); end

    // R5: falling, then rising
    cur_req = "R5";
    wr(0, 8'h12);
    for (int k = 0; k < 3; k++) begin idle(1, 4); idle(0, 4); wr(0, 8'h12); end
    wr(0, 8'h13);
    for (int k = 0; k < 3; k++) begin idle(1, 4); idle(0, 4); wr(0, 8'h13); end

    // R6: reserved mode
    cur_req = "R6";
    wr(0, 8'h11);
    for (int k = 0; k < 4; k++) begin idle(1, 3); idle(0, 3); end

    // R7: write-zero keeps, ack clears, set beats clear
    cur_req = "R7";
    wr(0, 8'h10); wr(0, 8'h00);
    idle(1, 4);
    wr(1, 8'h00); idle(1, 2);
    cyc(1, 1'b0, 8'h00, 1'b1, 1'b0); idle(1, 2);
    for (int i = 0; i < 30; i++) cyc((i / 3) % 2, 1'b1, 8'h10, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) cyc((i / 2) % 2, 1'b0, 8'h00, 1'b1, 1'b0);
    idle(0, 3);

    // R8: interrupt gating
    cur_req = "R8";
    wr(0, 8'h18);
    idle(1, 4);
    cyc(1, 1'b0, 8'h00, 1'b0, 1'b1); idle(1, 2);
    wr(1, 8'h00); idle(1, 2);
    wr(1, 8'h08); idle(1, 2);
    cyc(1, 1'b0, 8'h00, 1'b1, 1'b1); idle(1, 2);
    cyc(1, 1'b0, 8'h00, 1'b0, 1'b0); idle(1, 2);

    // R9: capture routing
    cur_req = "R9";
    wr(1, 8'h04);
    for (int k = 0; k < 3; k++) begin idle(0, 3); idle(1, 3); end
    wr(1, 8'h00); idle(0, 3); idle(1, 3);

    // R11: power-down freezes and blocks events
    cur_req = "R11";
    wr(1, 8'h10); idle(1, 3);
    wr(0, 8'h80);
    for (int k = 0; k < 3; k++) begin idle(0, 3); idle(1, 3); end
    idle(0, 2);
    wr(0, 8'h00); idle(0, 5);
    wr(0, 8'h90); idle(1, 3);
    wr(1, 8'h00); idle(1, 5);

    // mixed random traffic across all requirements
    cur_req = "R7";
    global_ie = 1'b1;
    for (int i = 0; i < 600; i++) begin
      bit [7:0] w;
      w = 8'($urandom);
      if (w[7] && ($urandom % 3 != 0)) w[7] = 1'b0;
      cyc(1'($urandom), ($urandom % 5 == 0), w, ($urandom % 7 == 0), 1'($urandom));
    end
    idle(0, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule